// File: doc/BRIEF.md
# Address Window to DRAM Bank Mapper

The CPU address space is split into four equal windows, picked by the two top address bits. Each window has a small map entry. The entry names the physical DRAM bank that serves that window, and it gives a two-bit offset. The offset drives two spare address lines into the row/column multiplexer, so one physical bank can appear in a window at any of four offsets. Software rewrites the entries through an I/O write strobe, which gives each window its own bank and offset. This makes it cheap to switch between tasks.

The lookup is combinational from the address bits, so the selected bank and the offset are valid in the same cycle that the address is presented. A write goes into the register file on a clock edge and only changes the entry it addresses. Reset clears every entry, so all four windows start on bank 0 with no offset.

Top module: `win_bank_map`

## Requirements
- R1: While rst_ni is low, and right after it is released, every window reads bank 0 with offset 0, so bank_sel_o = 4'b0001 and offset_o = 0.
- R2: In a 4-bit entry, bits [3:2] are the physical bank number and bits [1:0] are the offset driven on offset_o.
- R3: bank_sel_o is one-hot at all times: bit n is set exactly when the selected entry's bank number is n.
- R4: The outputs follow cpu_addr_hi_i in the same cycle, with no register between the window bits and the outputs.
- R5: When io_wr_i is high at a rising clk_i edge, entry io_idx_i takes the value io_data_i. The outputs show the new value only after that edge.
- R6: A write to one entry leaves the bank select and offset of every other window unchanged, including an access that is in progress.
- R7: When io_wr_i is low, no entry changes, whatever the values on io_idx_i and io_data_i.
- R8: One physical bank can be mapped into several windows at the same time, each window with its own offset.
- R9: Asserting rst_ni at any time clears all entries without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_wr_i | input | 1 | I/O write strobe for the map register file |
| io_idx_i | input | 2 | Index of the entry to write |
| io_data_i | input | 4 | Entry value: bank in [3:2], offset in [1:0] |
| cpu_addr_hi_i | input | 2 | CPU address bits 15:14, which select the window |
| bank_sel_o | output | 4 | One-hot physical bank select |
| offset_o | output | 2 | Offset driven onto the spare DRAM address lines |

## Verification
The mapping is exercised with several input patterns, and each pattern rules out a different kind of fault:

- **Distinct banks per window.** Four different banks are mapped to the four windows, each with its own offset. This catches swapped fields and misdecoded bank bits.
- **One bank in every window.** A single bank is mapped to all windows at different offsets. This shows that the offset is stored per entry and not shared.
- **Neighbour isolation.** Writes to one entry are made while another window is held on the address bits. This exposes a wrong write-enable decode.
- **Ignored strobes.** Index and data values are toggled with the strobe low. This must leave every entry unchanged.
- **Edge timing.** The outputs are sampled around the write edge. This separates a registered update from a combinational write-through.
- **Mid-run reset.** A reset pulse between clock edges shows that the clear is asynchronous.

// File: rtl/win_bank_map_pkg.sv
package win_bank_map_pkg;
  parameter int unsigned BANK_W   = 2;
  parameter int unsigned OFS_W    = 2;
  parameter int unsigned NUM_WIN  = 4;
  localparam int unsigned ENT_W    = BANK_W + OFS_W;
  localparam int unsigned NUM_BANK = 1 << BANK_W;
  localparam int unsigned IDX_W    = $clog2(NUM_WIN);

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [OFS_W-1:0]  ofs;
  } map_ent_t;
endpackage

// File: rtl/win_map_regs.sv
module win_map_regs
  import win_bank_map_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  map_ent_t         wr_ent_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output map_ent_t         rd_ent_o
);
  map_ent_t ent_q [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_ent
    logic wr_en;
    assign wr_en = wr_i && (wr_idx_i == IDX_W'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    ent_q[w] <= '0;
      else if (wr_en) ent_q[w] <= wr_ent_i;
    end
  end

  // combinational read: mapping valid in the same cycle as the address
  assign rd_ent_o = ent_q[rd_idx_i];
endmodule

// File: rtl/win_bank_dec.sv
module win_bank_dec
  import win_bank_map_pkg::*;
(
  input  logic [BANK_W-1:0]   bank_i,
  output logic [NUM_BANK-1:0] sel_o
);
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_sel
    assign sel_o[b] = (bank_i == BANK_W'(b));
  end
endmodule

// File: rtl/win_bank_map.sv
module win_bank_map
  import win_bank_map_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                io_wr_i,
  input  logic [IDX_W-1:0]    io_idx_i,
  input  logic [ENT_W-1:0]    io_data_i,
  input  logic [IDX_W-1:0]    cpu_addr_hi_i,
  output logic [NUM_BANK-1:0] bank_sel_o,
  output logic [OFS_W-1:0]    offset_o
);
  map_ent_t wr_ent, rd_ent;

  assign wr_ent = map_ent_t'(io_data_i);

  win_map_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (io_wr_i),
    .wr_idx_i (io_idx_i),
    .wr_ent_i (wr_ent),
    .rd_idx_i (cpu_addr_hi_i),
    .rd_ent_o (rd_ent)
  );

  win_bank_dec u_dec (
    .bank_i (rd_ent.bank),
    .sel_o  (bank_sel_o)
  );

  assign offset_o = rd_ent.ofs;
endmodule

// File: rtl/win_bank_map_chk.sv
module win_bank_map_chk
  import win_bank_map_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                io_wr_i,
  input logic [IDX_W-1:0]    io_idx_i,
  input logic [ENT_W-1:0]    io_data_i,
  input logic [IDX_W-1:0]    cpu_addr_hi_i,
  input logic [NUM_BANK-1:0] bank_sel_o,
  input logic [OFS_W-1:0]    offset_o
);
  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (bank_sel_o == NUM_BANK'(1)) && (offset_o == '0));

  // R3
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(bank_sel_o) == 1);

  // R5 R2
  wr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(io_wr_i) && $past(io_idx_i) == cpu_addr_hi_i) |->
      (offset_o == $past(io_data_i[OFS_W-1:0])) &&
      (bank_sel_o == (NUM_BANK'(1) << $past(io_data_i[ENT_W-1:OFS_W]))));

  // R6
  other_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(io_wr_i) && $past(io_idx_i) != cpu_addr_hi_i && $stable(cpu_addr_hi_i)) |->
      ($stable(bank_sel_o) && $stable(offset_o)));

  // R7
  no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(io_wr_i) && $stable(cpu_addr_hi_i)) |->
      ($stable(bank_sel_o) && $stable(offset_o)));
endmodule

bind win_bank_map win_bank_map_chk u_chk (.*);

// File: tb/win_bank_map_bench.sv
`timescale 1ns/1ps
module win_bank_map_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       io_wr_i = 1'b0;
  logic [1:0] io_idx_i = '0;
  logic [3:0] io_data_i = '0;
  logic [1:0] cpu_addr_hi_i = '0;
  logic [3:0] bank_sel_o;
  logic [1:0] offset_o;

  int checks = 0;
  int failures = 0;
  logic [3:0] mdl [4];

  win_bank_map u_win_bank_map (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [3:0] exp_sel, input logic [1:0] exp_ofs);
    checks++;
    if (bank_sel_o !== exp_sel || offset_o !== exp_ofs) begin
      failures++;
      $display("FAIL %s win=%0d sel=%b/%b ofs=%0d/%0d (actual/expected)",
               req, cpu_addr_hi_i, bank_sel_o, exp_sel, offset_o, exp_ofs);
    end
  endtask

  function automatic logic [3:0] sel_of(input logic [3:0] e);
    return 4'b0001 << e[3:2];
  endfunction

  task automatic chk_win(input string req, input int w);
    cpu_addr_hi_i = 2'(w);
    #1;
    chk(req, sel_of(mdl[w]), mdl[w][1:0]);
  endtask

  task automatic chk_all(input string req);
    for (int w = 0; w < 4; w++) chk_win(req, w);
  endtask

  task automatic do_wr(input int idx, input logic [3:0] d);
    @(negedge clk_i);
    io_wr_i = 1'b1; io_idx_i = 2'(idx); io_data_i = d;
    @(negedge clk_i);
    io_wr_i = 1'b0;
    mdl[idx] = d;
  endtask

  task automatic t_reset;
    for (int w = 0; w < 4; w++) mdl[w] = '0;
    chk_all("R1");
  endtask

  task automatic t_distinct;
    // R2 R3: bank in [3:2], offset in [1:0]
    do_wr(0, 4'b11_01);
    do_wr(1, 4'b10_10);
    do_wr(2, 4'b01_11);
    do_wr(3, 4'b00_00);
    chk_all("R2");
    chk_all("R3");
  endtask

  task automatic t_shared_bank;
    for (int w = 0; w < 4; w++) do_wr(w, {2'b10, 2'(w)});
    chk_all("R8");
  endtask

  task automatic t_comb_read;
    // R4: outputs follow address without a clock edge
    @(negedge clk_i);
    for (int w = 3; w >= 0; w--) chk_win("R4", w);
  endtask

  task automatic t_edge_timing;
    @(negedge clk_i);
    cpu_addr_hi_i = 2'd1;
    io_wr_i = 1'b1; io_idx_i = 2'd1; io_data_i = 4'b01_10;
    #2;
    chk("R5", sel_of(mdl[1]), mdl[1][1:0]);
    @(negedge clk_i);
    io_wr_i = 1'b0;
    mdl[1] = 4'b01_10;
    #1;
    chk("R5", sel_of(mdl[1]), mdl[1][1:0]);
  endtask

  task automatic t_isolation;
    // R6: hold window 2 while other entries are written
    @(negedge clk_i);
    cpu_addr_hi_i = 2'd2;
    for (int w = 0; w < 4; w++) begin
      if (w == 2) continue;
      io_wr_i = 1'b1; io_idx_i = 2'(w); io_data_i = 4'(4'hF - w);
      @(negedge clk_i);
      io_wr_i = 1'b0;
      mdl[w] = 4'(4'hF - w);
      #1;
      chk("R6", sel_of(mdl[2]), mdl[2][1:0]);
    end
    chk_all("R6");
  endtask

  task automatic t_no_write;
    @(negedge clk_i);
    io_wr_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      io_idx_i = 2'(i); io_data_i = 4'(i * 5 + 3);
      @(negedge clk_i);
    end
    chk_all("R7");
  endtask

  task automatic t_async_reset;
    do_wr(3, 4'b11_11);
    #3;
    rst_ni = 1'b0;
    #1;
    for (int w = 0; w < 4; w++) mdl[w] = '0;
    cpu_addr_hi_i = 2'd3;
    #1;
    chk("R9", 4'b0001, 2'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk_all("R9");
  endtask

  initial begin
    #1;
    t_reset();
    #22 rst_ni = 1'b1;
    t_reset();
    t_distinct();
    t_comb_read();
    t_shared_bank();
    t_edge_timing();
    t_isolation();
    t_no_write();
    t_async_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule